// File: doc/BRIEF.md
# Auto-Baud UART Command Port

This block is the asynchronous serial port of an isolated data-acquisition slave. It never receives a programmed divisor. After reset it watches the receive line for a calibration character and times the low start bit of that character in system clocks. If the length falls inside the supported rate window, that length becomes the bit period. The port then uses this period in both directions for as long as the block stays out of reset.

Once locked, the receiver looks for start edges and confirms each start bit at its midpoint. It samples every data bit at the centre of its bit time, then either delivers the byte with a one-cycle strobe or flags a bad stop bit. The transmitter takes one byte at a time through a request/busy handshake and serialises it at the same measured period. Receive and transmit run independently, so both can be active at once.

Top module: `abu_autobaud_uart`

## Requirements
- R1: A character is a low start bit, eight data bits sent least-significant bit first, and a high stop bit, each one period long. A correctly framed character produces a one-cycle `rx_valid_o` pulse, with `rx_data_o` holding the byte during that pulse.
- R2: Immediately after reset, `txd_o` is high, and `locked_o`, `tx_busy_o`, `rx_valid_o` and `rx_ferr_o` are all low.
- R3: The first falling edge after the line has been high starts a timing measurement. The count of clocks until the next rising edge becomes the bit period. `locked_o` rises and stays high when that count lies within MIN_DIV..MAX_DIV, and the rest of the calibration character is never delivered as data. The calibration character must have bit 0 set to 1.
- R4: A low run shorter than MIN_DIV or longer than MAX_DIV clocks does not set `locked_o`.
- R5: After lock, a start pulse that is high again half a period after its falling edge is discarded, and neither strobe is raised.
- R6: A character whose stop bit is sampled low raises `rx_ferr_o` for one cycle, does not raise `rx_valid_o`, and is never pulsed together with `rx_valid_o`.
- R7: The transmitter sends the accepted byte on `txd_o` in the R1 format at the measured period, and `txd_o` idles high.
- R8: A request on `tx_start_i` is accepted only while `tx_busy_o` is low. `tx_busy_o` stays high for the whole character, and a request made while it is high is ignored.
- R9: While `locked_o` is low, a request on `tx_start_i` is refused: `tx_busy_o` stays low and `txd_o` stays high.
- R10: Receiving and transmitting can overlap in time without corrupting either byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| txd_o | output | 1 | Serial transmit line, idle high |
| rx_valid_o | output | 1 | One-cycle strobe: a good byte was received |
| rx_data_o | output | 8 | Last received byte |
| rx_ferr_o | output | 1 | One-cycle strobe: stop bit was low |
| tx_start_i | input | 1 | Request to send `tx_data_i` |
| tx_data_i | input | 8 | Byte to send |
| tx_busy_o | output | 1 | Transmitter is sending a character |
| locked_o | output | 1 | Bit period has been measured and accepted |

## Verification
Calibration is tried with low runs that are too short, too long and inside the window. These show whether the window bounds are applied on both sides and whether a rejected measurement leaves the port unlocked. Receive traffic uses fixed patterns (all zeros, all ones, alternating bits) and seeded random bytes. The fixed patterns separate a bit-order or bit-count error from a sampling-offset error. A short low glitch and a character with a low stop bit each probe one of the two discard paths. Transmit bytes are decoded at the bench's own period, sent alone, overlapped with receive traffic, and sent with an extra request while busy, which shows whether the handshake gating and full-duplex independence hold.

// File: rtl/abu_pkg.sv
package abu_pkg;

    typedef enum logic [2:0] {
        CAL_ARM,
        CAL_IDLE,
        CAL_MEAS,
        CAL_SKIP,
        CAL_DONE
    } cal_st_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_e;

endpackage

// File: rtl/abu_line_sync.sv
module abu_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = line_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1};
        else        q <= d;
    end

    assign line_o = q.s2;
    assign fall_o = q.s3 & ~q.s2;
    assign rise_o = ~q.s3 & q.s2;
endmodule

// File: rtl/abu_baud_lock.sv
module abu_baud_lock import abu_pkg::*; #(
    parameter int MIN_DIV = 855,
    parameter int MAX_DIV = 3334,
    parameter int DIV_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             fall_i,
    input  logic             rise_i,
    output logic             locked_o,
    output logic [DIV_W-1:0] div_o
);
    localparam int CW = DIV_W + 4;

    typedef struct packed {
        cal_st_e          st;
        logic [CW-1:0]    cnt;
        logic [DIV_W-1:0] div;
    } lock_t;

    lock_t q, d;
    logic [CW-1:0] run_len;
    logic [CW-1:0] skip_len;

    always_comb begin
        d        = q;
        run_len  = q.cnt + CW'(1);
        skip_len = (CW'(q.div) << 3) + CW'(q.div >> 1);
        case (q.st)
            CAL_ARM:  if (line_i) d.st = CAL_IDLE;
            CAL_IDLE: if (fall_i) begin
                d.st  = CAL_MEAS;
                d.cnt = '0;
            end
            CAL_MEAS: begin
                if (rise_i) begin
                    if (run_len >= CW'(MIN_DIV) && run_len <= CW'(MAX_DIV)) begin
                        d.div = DIV_W'(run_len);
                        d.st  = CAL_SKIP;
                        d.cnt = '0;
                    end else begin
                        d.st = CAL_IDLE;
                    end
                end else if (q.cnt >= CW'(MAX_DIV)) begin
                    d.st = CAL_ARM;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            CAL_SKIP: begin
                if (q.cnt == skip_len - CW'(1)) d.st = CAL_DONE;
                else                            d.cnt = q.cnt + CW'(1);
            end
            default: d.st = CAL_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CAL_ARM, cnt: '0, div: '0};
        else        q <= d;
    end

    assign locked_o = (q.st == CAL_DONE);
    assign div_o    = q.div;

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    // R4
    div_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (int'(div_o) >= MIN_DIV && int'(div_o) <= MAX_DIV));
endmodule

// File: rtl/abu_rx.sv
module abu_rx import abu_pkg::*; #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             line_i,
    input  logic             fall_i,
    output logic             valid_o,
    output logic [7:0]       data_o,
    output logic             ferr_o
);
    typedef struct packed {
        rx_st_e           st;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic [7:0]       data;
        logic             valid;
        logic             ferr;
    } rx_t;

    rx_t q, d;
    logic [DIV_W-1:0] half;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.ferr  = 1'b0;
        half    = div_i >> 1;
        case (q.st)
            RX_IDLE: if (locked_i && fall_i) begin
                d.st  = RX_START;
                d.cnt = '0;
            end
            RX_START: begin
                if (q.cnt == half - DIV_W'(1)) begin
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.st   = line_i ? RX_IDLE : RX_DATA;
                end else begin
                    d.cnt = q.cnt + DIV_W'(1);
                end
            end
            RX_DATA: begin
                if (q.cnt == div_i - DIV_W'(1)) begin
                    d.cnt = '0;
                    d.sh  = {line_i, q.sh[7:1]};
                    if (q.bitn == 3'd7) d.st = RX_STOP;
                    else                d.bitn = q.bitn + 3'd1;
                end else begin
                    d.cnt = q.cnt + DIV_W'(1);
                end
            end
            default: begin
                if (q.cnt == div_i - DIV_W'(1)) begin
                    d.st = RX_IDLE;
                    if (line_i) begin
                        d.valid = 1'b1;
                        d.data  = q.sh;
                    end else begin
                        d.ferr = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + DIV_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, cnt: '0, bitn: '0, sh: '0,
                           data: '0, valid: 1'b0, ferr: 1'b0};
        else        q <= d;
    end

    assign valid_o = q.valid;
    assign data_o  = q.data;
    assign ferr_o  = q.ferr;

    // R1
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6
    no_dual_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && ferr_o));
endmodule

// File: rtl/abu_tx.sv
module abu_tx #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             start_i,
    input  logic [7:0]       data_i,
    output logic             txd_o,
    output logic             busy_o
);
    typedef struct packed {
        logic             busy;
        logic [9:0]       sh;
        logic [DIV_W-1:0] cnt;
        logic [3:0]       bitn;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start_i && locked_i) begin
                d.sh   = {1'b1, data_i, 1'b0};
                d.cnt  = '0;
                d.bitn = '0;
                d.busy = 1'b1;
            end
        end else if (q.cnt == div_i - DIV_W'(1)) begin
            d.cnt = '0;
            d.sh  = {1'b1, q.sh[9:1]};
            if (q.bitn == 4'd9) d.busy = 1'b0;
            else                d.bitn = q.bitn + 4'd1;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sh: '1, cnt: '0, bitn: '0};
        else        q <= d;
    end

    assign txd_o  = q.sh[0];
    assign busy_o = q.busy;

    // R9
    idle_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_i |-> (txd_o && !busy_o));

    // R8
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i && locked_i));
endmodule

// File: rtl/abu_autobaud_uart.sv
module abu_autobaud_uart #(
    parameter int MIN_DIV = 855,
    parameter int MAX_DIV = 3334
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    output logic       txd_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       rx_ferr_o,
    input  logic       tx_start_i,
    input  logic [7:0] tx_data_i,
    output logic       tx_busy_o,
    output logic       locked_o
);
    localparam int DIV_W = $clog2(MAX_DIV + 1);

    logic             line_s, fall_s, rise_s;
    logic [DIV_W-1:0] div;

    abu_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(rxd_i),
        .line_o(line_s), .fall_o(fall_s), .rise_o(rise_s)
    );

    abu_baud_lock #(.MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_W(DIV_W)) u_lock (
        .clk(clk), .rst_n(rst_n), .line_i(line_s), .fall_i(fall_s),
        .rise_i(rise_s), .locked_o(locked_o), .div_o(div)
    );

    abu_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .locked_i(locked_o), .div_i(div),
        .line_i(line_s), .fall_i(fall_s), .valid_o(rx_valid_o),
        .data_o(rx_data_o), .ferr_o(rx_ferr_o)
    );

    abu_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .locked_i(locked_o), .div_i(div),
        .start_i(tx_start_i), .data_i(tx_data_i), .txd_o(txd_o),
        .busy_o(tx_busy_o)
    );
endmodule

// File: tb/abu_autobaud_uart_tb.sv
module abu_autobaud_uart_tb;
    localparam int MIN_DIV = 20;
    localparam int MAX_DIV = 80;
    localparam int DIV     = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic txd, rx_valid, rx_ferr, tx_busy, locked;
    logic [7:0] rx_data;
    logic tx_start = 1'b0;
    logic [7:0] tx_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int ferr_cnt = 0;
    logic [7:0] rx_got[$];
    logic [7:0] tx_got[$];

    always #2.5 clk = ~clk;

    abu_autobaud_uart #(.MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .txd_o(txd),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_ferr_o(rx_ferr),
        .tx_start_i(tx_start), .tx_data_i(tx_data), .tx_busy_o(tx_busy),
        .locked_o(locked)
    );

    function automatic logic [9:0] frame_of(logic [7:0] b, logic stop);
        return {stop, b, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_frame(input logic [9:0] f, input int per);
        for (int i = 0; i < 10; i++) begin
            rxd = f[i];
            repeat (per) @(negedge clk);
        end
        rxd = 1'b1;
    endtask

    task automatic wait_q_rx(input int lim);
        for (int i = 0; i < lim && rx_got.size() == 0; i++) @(negedge clk);
    endtask

    task automatic wait_q_tx(input int lim);
        for (int i = 0; i < lim && tx_got.size() == 0; i++) @(negedge clk);
    endtask

    task automatic rx_byte(input logic [7:0] b, input string req);
        logic [7:0] g;
        drive_frame(frame_of(b, 1'b1), DIV);
        wait_q_rx(4 * DIV);
        g = (rx_got.size() > 0) ? rx_got.pop_front() : 8'hxx;
        chk(g === b, req, int'(g), int'(b));
    endtask

    task automatic tx_req(input logic [7:0] b);
        while (tx_busy) @(negedge clk);
        tx_data  = b;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic tx_byte(input logic [7:0] b, input string req);
        logic [7:0] g;
        tx_req(b);
        wait_q_tx(14 * DIV);
        g = (tx_got.size() > 0) ? tx_got.pop_front() : 8'hxx;
        chk(g === b, req, int'(g), int'(b));
    endtask

    // receive monitor
    always @(negedge clk) begin
        if (rx_valid) rx_got.push_back(rx_data);
        if (rx_ferr) ferr_cnt++;
    end

    // transmit decoder at the bench's own period
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (DIV / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (DIV) @(negedge clk);
                    b[i] = txd;
                end
                repeat (DIV) @(negedge clk);
                chk(txd === 1'b1, "R7 stop high", int'(txd), 1);
                tx_got.push_back(b);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int fe0, rc0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R2 reset state
        chk(txd === 1'b1 && !locked && !tx_busy && !rx_valid && !rx_ferr,
            "R2 reset state", {txd, locked, tx_busy, rx_valid, rx_ferr}, 5'b10000);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9 request before lock
        tx_req(8'hA5);
        repeat (3 * DIV) @(negedge clk);
        chk(!tx_busy && txd === 1'b1, "R9 refused before lock", {tx_busy, txd}, 2'b01);

        // R4 too-short run
        drive_frame(frame_of(8'h55, 1'b1), 10);
        repeat (2 * DIV) @(negedge clk);
        chk(!locked, "R4 short run rejected", int'(locked), 0);
        // R4 too-long run
        rxd = 1'b0;
        repeat (MAX_DIV + 20) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * DIV) @(negedge clk);
        chk(!locked, "R4 long run rejected", int'(locked), 0);

        // R3 calibration with zeros in the upper bits
        drive_frame(frame_of(8'h5B, 1'b1), DIV);
        repeat (2 * DIV) @(negedge clk);
        chk(locked, "R3 lock", int'(locked), 1);
        chk(rx_got.size() == 0 && ferr_cnt == 0, "R3 calibration byte not delivered",
            rx_got.size() + ferr_cnt, 0);

        // R1 directed and random bytes
        rx_byte(8'h00, "R1 zeros");
        rx_byte(8'hFF, "R1 ones");
        rx_byte(8'hA5, "R1 alternating");
        for (int i = 0; i < 8; i++) rx_byte(8'($urandom), "R1 random");

        // R5 glitch
        fe0 = ferr_cnt;
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * DIV) @(negedge clk);
        chk(rx_got.size() == 0 && ferr_cnt == fe0, "R5 glitch ignored",
            rx_got.size() + ferr_cnt - fe0, 0);

        // R6 framing error
        drive_frame(frame_of(8'h3C, 1'b0), DIV);
        repeat (2 * DIV) @(negedge clk);
        chk(ferr_cnt == fe0 + 1, "R6 ferr pulse", ferr_cnt - fe0, 1);
        chk(rx_got.size() == 0, "R6 byte discarded", rx_got.size(), 0);
        rx_byte(8'h81, "R6 recovery");

        // R7 transmit
        tx_byte(8'h00, "R7 zeros");
        tx_byte(8'hC3, "R7 pattern");
        for (int i = 0; i < 5; i++) tx_byte(8'($urandom), "R7 random");

        // R8 busy gating
        tx_req(8'h96);
        repeat (3 * DIV) @(negedge clk);
        chk(tx_busy, "R8 busy mid-frame", int'(tx_busy), 1);
        tx_data  = 8'h69;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        wait_q_tx(14 * DIV);
        rc0 = tx_got.size();
        chk(rc0 == 1 && tx_got[0] === 8'h96, "R8 first byte kept",
            (rc0 > 0) ? int'(tx_got[0]) : -1, 8'h96);
        if (rc0 > 0) void'(tx_got.pop_front());
        repeat (14 * DIV) @(negedge clk);
        chk(tx_got.size() == 0 && !tx_busy, "R8 busy request ignored", tx_got.size(), 0);

        // R10 full duplex
        for (int i = 0; i < 3; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            fork
                rx_byte(a, "R10 rx overlap");
                tx_byte(b, "R10 tx overlap");
            join
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule